// File: doc/BRIEF.md
# Cascaded Interrupt Status Encoder

This block collects interrupt requests from three groups (critical, main and peripheral) and condenses them into a single registered status word. Each group has its own field in that word, made of a valid flag and a code. Within each group the lowest-numbered active source wins. Software services the critical field first, then the main field, then the peripheral field. A request line to the core is high whenever any group flag is set.

The encoder is cascaded. The peripheral winner is split into two priority classes by a parameter vector. A high-class peripheral winner appears in the critical group as code 2. A low-class winner appears in the main group as code 4. Peripheral source 0 is not a pin. It stands for an embedded DMA task controller, which keeps a 32-bit pending register. Software clears that register by writing ones, and its lowest unmasked pending task is also reported in the status word.

Software configures the block through a simple write port with a 2-bit register select. Select 0 is the main mask, 1 the peripheral mask, 2 the DMA mask and 3 the DMA pending clear. In every mask a set bit disables the source.

Top module: `irq_cascade_enc`

## Requirements
- R1: After reset the status word, the DMA pending register and `core_irq` are 0. The main mask reads 0x00010fff, the peripheral mask 0x7ffffc00 and the DMA mask 0xffffffff.
- R2: One cycle after a change in the requests, status bit 10 is set when a critical source is active and bits 9:8 give the lowest active index. The critical request input at index 2 is ignored, because that slot is reserved for the peripheral pointer.
- R3: Main source n is disabled by main mask bit 16-n. Status bit 21 flags an unmasked main source, and bits 20:16 give the lowest such index. The main request input at index 4 is ignored, because that slot is reserved for the peripheral pointer.
- R4: Peripheral source n is disabled by peripheral mask bit 31-n. Status bit 29 flags an unmasked peripheral source, and bits 28:24 give the lowest such index.
- R5: A peripheral winner whose bit is set in `PER_HI` (by default sources 1 to 3) enters the critical group as code 2. Any other peripheral winner enters the main group as code 4, and main mask bit 12 can disable that entry.
- R6: Peripheral source 0 is active when any DMA task is both pending and unmasked, and DMA task n is masked by DMA mask bit n. Status bit 7 flags such a task, and bits 4:0 give the lowest one. Input `per_req[0]` is ignored.
- R7: A 1 on `dma_req[n]` sets pending bit n at the next edge. A write with select 3 clears the pending bits where the data bit is 1 and leaves bits with data 0 unchanged. A new request beats a clear in the same cycle.
- R8: A write with select 0, 1 or 2 replaces the main, peripheral or DMA mask at the next edge. The status word reflects the new mask one cycle after that.
- R9: `core_irq` is high exactly when status bit 10, 21 or 29 is set, and it changes in the same cycle as the status word.
- R10: When a group's only request goes away, its flag clears on the next cycle and its code field reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| crit_req | input | 4 | Critical group requests (index 2 unused) |
| main_req | input | 17 | Main group requests (index 4 unused) |
| per_req | input | 32 | Peripheral group requests (index 0 unused) |
| dma_req | input | 32 | DMA task completion events, one per task |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 main mask, 1 peripheral mask, 2 DMA mask, 3 DMA pending clear |
| wr_data | input | 32 | Write data |
| status | output | 32 | Encoded status word |
| main_mask | output | 32 | Main mask register |
| per_mask | output | 32 | Peripheral mask register |
| dma_mask | output | 32 | DMA mask register |
| dma_pend | output | 32 | DMA pending register |
| core_irq | output | 1 | Interrupt request to the core |

## Verification
Changes on the group request pins reach the status word after one rising edge. A mask write or a DMA pending update needs one edge to land in its register and a second edge to reach the status word, and `dma_pend` itself is visible after the first edge. The bench drives every input on a falling edge and samples on a later falling edge, after exactly the number of rising edges listed above. It also checks a few intermediate cycles, where the status word must still show the old value, to confirm that the second edge is really needed.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;

    typedef enum logic [1:0] {
        SEL_MAIN_MASK = 2'd0,
        SEL_PER_MASK  = 2'd1,
        SEL_DMA_MASK  = 2'd2,
        SEL_PEND_CLR  = 2'd3
    } wr_sel_e;

    typedef struct packed {
        logic [31:0] main_mask;
        logic [31:0] per_mask;
        logic [31:0] dma_mask;
        logic [31:0] dma_pend;
    } cfg_regs_t;

    typedef struct packed {
        logic [31:0] status;
    } enc_state_t;

endpackage

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int N = 32,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    output logic         valid,
    output logic [W-1:0] idx
);
    always_comb begin
        valid = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_cascade_pkg::*;
#(
    parameter logic [31:0] MAIN_MASK_RST = 32'h0001_0fff,
    parameter logic [31:0] PER_MASK_RST  = 32'h7fff_fc00,
    parameter logic [31:0] DMA_MASK_RST  = 32'hffff_ffff
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic [31:0] dma_req,
    output logic [31:0] main_mask,
    output logic [31:0] per_mask,
    output logic [31:0] dma_mask,
    output logic [31:0] dma_pend
);
    cfg_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_MAIN_MASK: regs_d.main_mask = wr_data;
                SEL_PER_MASK:  regs_d.per_mask  = wr_data;
                SEL_DMA_MASK:  regs_d.dma_mask  = wr_data;
                SEL_PEND_CLR:  regs_d.dma_pend  = regs_q.dma_pend & ~wr_data;
                default:       regs_d = regs_q;
            endcase
        end
        regs_d.dma_pend = regs_d.dma_pend | dma_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.main_mask <= MAIN_MASK_RST;
            regs_q.per_mask  <= PER_MASK_RST;
            regs_q.dma_mask  <= DMA_MASK_RST;
            regs_q.dma_pend  <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign main_mask = regs_q.main_mask;
    assign per_mask  = regs_q.per_mask;
    assign dma_mask  = regs_q.dma_mask;
    assign dma_pend  = regs_q.dma_pend;

    // R7: cleared bits without a fresh request read 0 after the write
    p_pend_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_PEND_CLR)
        |=> ((dma_pend & $past(wr_data & ~dma_req)) == 32'h0));

    // R7: without a clear write no pending bit is lost
    p_pend_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == SEL_PEND_CLR)
        |=> ((dma_pend & $past(dma_pend)) == $past(dma_pend)));

    // R7: a request always lands in the pending register
    p_pend_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|dma_req) |=> ((dma_pend & $past(dma_req)) == $past(dma_req)));
endmodule

// File: rtl/irq_cascade_enc.sv
module irq_cascade_enc
    import irq_cascade_pkg::*;
#(
    parameter int          N_CRIT        = 4,
    parameter int          N_MAIN        = 17,
    parameter int          N_PER         = 32,
    parameter int          N_DMA         = 32,
    parameter int          CRIT_PTR      = 2,
    parameter int          MAIN_PTR      = 4,
    parameter logic [31:0] PER_HI        = 32'h0000_000e,
    parameter logic [31:0] MAIN_MASK_RST = 32'h0001_0fff,
    parameter logic [31:0] PER_MASK_RST  = 32'h7fff_fc00,
    parameter logic [31:0] DMA_MASK_RST  = 32'hffff_ffff
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CRIT-1:0] crit_req,
    input  logic [N_MAIN-1:0] main_req,
    input  logic [N_PER-1:0]  per_req,
    input  logic [N_DMA-1:0]  dma_req,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [31:0]       wr_data,
    output logic [31:0]       status,
    output logic [31:0]       main_mask,
    output logic [31:0]       per_mask,
    output logic [31:0]       dma_mask,
    output logic [31:0]       dma_pend,
    output logic              core_irq
);
    localparam int CRIT_W   = $clog2(N_CRIT);
    localparam int MAIN_W   = $clog2(N_MAIN);
    localparam int PER_W    = $clog2(N_PER);
    localparam int DMA_W    = $clog2(N_DMA);
    localparam int MAIN_MSB = N_MAIN - 1;
    localparam int PER_MSB  = N_PER - 1;

    irq_cfg_regs #(
        .MAIN_MASK_RST(MAIN_MASK_RST),
        .PER_MASK_RST (PER_MASK_RST),
        .DMA_MASK_RST (DMA_MASK_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .dma_req  (32'(dma_req)),
        .main_mask(main_mask),
        .per_mask (per_mask),
        .dma_mask (dma_mask),
        .dma_pend (dma_pend)
    );

    // mask bit order: reversed for main and peripheral, direct for DMA
    logic [N_MAIN-1:0] main_en;
    logic [N_PER-1:0]  per_en;
    logic [N_DMA-1:0]  dma_act;

    for (genvar n = 0; n < N_MAIN; n++) begin : g_main_en
        assign main_en[n] = ~main_mask[MAIN_MSB - n];
    end
    for (genvar n = 0; n < N_PER; n++) begin : g_per_en
        assign per_en[n] = ~per_mask[PER_MSB - n];
    end
    assign dma_act = dma_pend[N_DMA-1:0] & ~dma_mask[N_DMA-1:0];

    // DMA stage: lowest unmasked pending task
    logic             dma_v;
    logic [DMA_W-1:0] dma_idx;
    irq_lowest_pick #(.N(N_DMA)) u_pick_dma (.req(dma_act), .valid(dma_v), .idx(dma_idx));

    // peripheral stage: slot 0 is the DMA cascade
    logic [N_PER-1:0] per_act;
    logic             per_v;
    logic [PER_W-1:0] per_idx;
    always_comb begin
        per_act    = per_req;
        per_act[0] = dma_v;
        per_act    = per_act & per_en;
    end
    irq_lowest_pick #(.N(N_PER)) u_pick_per (.req(per_act), .valid(per_v), .idx(per_idx));

    logic per_hi_win, per_lo_win;
    assign per_hi_win = per_v &  PER_HI[per_idx];
    assign per_lo_win = per_v & ~PER_HI[per_idx];

    // critical stage: slot CRIT_PTR points at a high-class peripheral
    logic [N_CRIT-1:0] crit_act;
    logic              crit_v;
    logic [CRIT_W-1:0] crit_idx;
    always_comb begin
        crit_act           = crit_req;
        crit_act[CRIT_PTR] = per_hi_win;
    end
    irq_lowest_pick #(.N(N_CRIT)) u_pick_crit (.req(crit_act), .valid(crit_v), .idx(crit_idx));

    // main stage: slot MAIN_PTR points at a low-class peripheral
    logic [N_MAIN-1:0] main_act;
    logic              main_v;
    logic [MAIN_W-1:0] main_idx;
    always_comb begin
        main_act           = main_req;
        main_act[MAIN_PTR] = per_lo_win;
        main_act           = main_act & main_en;
    end
    irq_lowest_pick #(.N(N_MAIN)) u_pick_main (.req(main_act), .valid(main_v), .idx(main_idx));

    enc_state_t st_d, st_q;

    always_comb begin
        st_d.status              = '0;
        st_d.status[8 +: CRIT_W] = crit_idx;
        st_d.status[10]          = crit_v;
        st_d.status[16 +: MAIN_W] = main_idx;
        st_d.status[21]          = main_v;
        st_d.status[24 +: PER_W] = per_idx;
        st_d.status[29]          = per_v;
        st_d.status[0 +: DMA_W]  = dma_idx;
        st_d.status[7]           = dma_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status   = st_q.status;
    assign core_irq = st_q.status[10] | st_q.status[21] | st_q.status[29];

    // R5: critical code 2 always comes with a peripheral winner
    p_crit_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (status[10] && status[9:8] == 2'(CRIT_PTR)) |-> status[29]);

    // R5: main code 4 always comes with a peripheral winner
    p_main_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (status[21] && status[20:16] == 5'(MAIN_PTR)) |-> status[29]);

    // R6: peripheral code 0 means a DMA task is reported
    p_dma_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status[29] && status[28:24] == 5'd0) |-> status[7]);

    // R4: the reported peripheral was enabled in the cycle it was picked
    p_per_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        status[29] |-> ((($past(per_en) >> status[28:24]) & N_PER'(1)) != '0));

    // R10: an idle group shows code 0
    p_code_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[10] |-> status[9:8] == 2'd0) and
        (!status[21] |-> status[20:16] == 5'd0) and
        (!status[29] |-> status[28:24] == 5'd0));
endmodule

// File: tb/irq_cascade_enc_tb.sv
module irq_cascade_enc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  crit_req = '0;
    logic [16:0] main_req = '0;
    logic [31:0] per_req = '0;
    logic [31:0] dma_req = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] status, main_mask, per_mask, dma_mask, dma_pend;
    logic        core_irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_cascade_enc u_dut (
        .clk(clk), .rst_n(rst_n), .crit_req(crit_req), .main_req(main_req),
        .per_req(per_req), .dma_req(dma_req), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .status(status), .main_mask(main_mask),
        .per_mask(per_mask), .dma_mask(dma_mask), .dma_pend(dma_pend),
        .core_irq(core_irq)
    );

    // {crit 4, main 17, per 32, expected status 32}, reset masks, no DMA
    localparam logic [84:0] TAB [0:12] = '{
        {4'b0001, 17'h00000, 32'h0000_0000, 32'h0000_0400},
        {4'b1000, 17'h00000, 32'h0000_0000, 32'h0000_0700},
        {4'b1010, 17'h00000, 32'h0000_0000, 32'h0000_0500},
        {4'b0100, 17'h00000, 32'h0000_0000, 32'h0000_0000},
        {4'b0000, 17'h00002, 32'h0000_0000, 32'h0021_0000},
        {4'b0000, 17'h0000c, 32'h0000_0000, 32'h0022_0000},
        {4'b0000, 17'h00001, 32'h0000_0000, 32'h0000_0000},
        {4'b0000, 17'h00020, 32'h0000_0000, 32'h0000_0000},
        {4'b0000, 17'h00000, 32'h0040_0000, 32'h3624_0000},
        {4'b0000, 17'h00000, 32'h0000_0002, 32'h0000_0000},
        {4'b0000, 17'h00000, 32'h0000_0001, 32'h0000_0000},
        {4'b0001, 17'h00002, 32'h0200_0000, 32'h3921_0400},
        {4'b0000, 17'h00010, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 status", status, 32'h0);
        chk("R1 core_irq", {31'h0, core_irq}, 32'h0);
        chk("R1 main_mask", main_mask, 32'h0001_0fff);
        chk("R1 per_mask", per_mask, 32'h7fff_fc00);
        chk("R1 dma_mask", dma_mask, 32'hffff_ffff);
        chk("R1 dma_pend", dma_pend, 32'h0);

        // vector table: R2 R3 R4 R5 R6 R9
        for (int i = 0; i < 13; i++) begin
            crit_req = TAB[i][84:81];
            main_req = TAB[i][80:64];
            per_req  = TAB[i][63:32];
            step();
            chk($sformatf("R2/R3/R4/R5 vec%0d status", i), status, TAB[i][31:0]);
            chk($sformatf("R9 vec%0d core_irq", i), {31'h0, core_irq},
                {31'h0, TAB[i][10] | TAB[i][21] | TAB[i][29]});
        end
        crit_req = '0; main_req = '0; per_req = '0;
        step();

        // R8 and R5: enable all peripherals, high-class source 1 -> critical code 2
        wr(2'd1, 32'h0);
        chk("R8 per_mask", per_mask, 32'h0);
        per_req = 32'h2;
        step();
        chk("R5 high class", status, 32'h2100_0600);
        // R5: mask main slot 4, low-class source 22 stays out of main
        per_req = 32'h0;
        wr(2'd0, 32'h0001_1000);
        chk("R8 main_mask", main_mask, 32'h0001_1000);
        per_req = 32'h0040_0000;
        step();
        chk("R5 pointer masked", status, 32'h3600_0000);
        per_req = 32'h0;
        wr(2'd0, 32'h0001_0fff);

        // R6/R7: enable DMA tasks 0..3, pulse tasks 3 and 5
        wr(2'd2, 32'hffff_fff0);
        dma_req = 32'h28;
        step();
        dma_req = '0;
        chk("R7 set", dma_pend, 32'h28);
        chk("R8 status one edge after pend", status, 32'h0);
        step();
        chk("R6 cascade", status, 32'h2024_0083);
        chk("R9 cascade irq", {31'h0, core_irq}, 32'h1);
        wr(2'd3, 32'h0);
        chk("R7 zero write", dma_pend, 32'h28);
        wr(2'd3, 32'h8);
        chk("R7 w1c", dma_pend, 32'h20);
        step();
        chk("R6 masked task", status, 32'h0);
        chk("R9 idle irq", {31'h0, core_irq}, 32'h0);
        // R7: set beats clear
        dma_req = 32'h20; wr_en = 1'b1; wr_sel = 2'd3; wr_data = 32'h20;
        step();
        dma_req = '0; wr_en = 1'b0; wr_data = '0;
        chk("R7 set beats clear", dma_pend, 32'h20);
        wr(2'd2, 32'h0);
        step();
        chk("R6 task 5", status, 32'h2024_0085);
        wr(2'd3, 32'hffff_ffff);
        step();
        chk("R7 clear all", dma_pend, 32'h0);
        chk("R6 cleared", status, 32'h0);

        // R10: removal
        crit_req = 4'b1000;
        step();
        chk("R10 present", status, 32'h0000_0700);
        crit_req = '0;
        step();
        chk("R10 dropped", status, 32'h0);
        chk("R10 irq dropped", {31'h0, core_irq}, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule